// File: doc/BRIEF.md
# Per-Pin Event Interrupt Bank

This block serves a bank of general-purpose pins. Each pin has its own 4 KiB register window holding four 32-bit words. The words are a pad configuration word, a data word, an interrupt setup word and a sticky interrupt flag. Every pin input passes through a two-stage synchroniser. A detector then watches the synchronised sample for a level or for edges. An event sets the pin's sticky flag when the pin allows raw latching. Software clears the flag by writing zero to the flag word.

The flags feed one active-high summary interrupt line. A pin counts toward that line only when all of these hold: its interrupt is enabled, direct routing is off, and its destination field names this processor. The processor identity is a parameter with a default of 4. Software reaches the registers through a word-wide port with separate read and write strobes. Read data is registered.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every stored field is zero, `pin_oe`, `pin_out` and `irq_out` are low, and every register reads zero except the sampled-input bit.
- R2: Pin p's window starts at byte address p*0x1000. Inside the window: 0x0 is the pad word (bits 1:0 pull, 5:2 function, 8:6 drive, 9 output enable), 0x4 is the data word, 0x8 is the interrupt setup word (bits 8:0) and 0xC is the flag word. Unused bits read zero, and any other offset reads zero and ignores writes.
- R3: `pin_oe[p]` follows bit 9 of the pad word and `pin_out[p]` follows bit 1 of the data word. Data word bit 0 reads the synchronised input, which reflects a pin change two clock edges later.
- R4: Mode 0 (setup bits 3:2 = 0) is level mode. The flag is set on every cycle in which the synchronised input equals the polarity bit (setup bit 1). A clear issued while that level persists does not take effect.
- R5: Mode 1 latches a rising edge, mode 2 a falling edge and mode 3 either edge. An edge is the current synchronised sample differing from the previous one. Polarity bit 1 = 0 inverts the input before detection, so mode 1 then fires on a falling pin.
- R6: Events latch into the flag only when raw-latch enable (setup bit 4) is 1. Interrupt enable (setup bit 0) has no effect on latching.
- R7: A write to the flag word with bit 0 = 0 clears the flag. A write with bit 0 = 1 leaves it unchanged. When a clear and an event meet in the same cycle, the flag stays set.
- R8: `irq_out` is high exactly when some pin has flag = 1, enable (bit 0) = 1, direct routing (bit 8) = 0 and destination (bits 7:5) equal to PROC_ID. A destination of 7 never matches.
- R9: A pin held high through reset produces no edge event once reset is released.
- R10: Read data appears on `reg_rdata` the cycle after `reg_rd` is sampled high, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address (pin index above bit 11) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| pin_in | input | NUM_PINS | Raw pin inputs |
| pin_out | output | NUM_PINS | Output values |
| pin_oe | output | NUM_PINS | Output enables |
| irq_out | output | 1 | Summary interrupt, active high |

## Verification
The bench holds a pin high through reset and enables rising detection at once. A synchroniser whose history is not primed would latch a false edge there. In level mode it issues a clear while the level is still present. A design that let the clear win would drop a live interrupt. It sweeps the destination, direct-routing and enable fields on a set flag, which catches any qualifier that leaks to the summary line. It also runs every edge mode with inverted polarity and writes a one to the flag word. Polarity applied to only one mode, or a flag that clears on any write, would show up there as a wrong flag value.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int WIN_BITS = 12;
  localparam int CFG_W    = 10;
  localparam int ICFG_W   = 9;
  localparam int TGT_W    = 3;

  typedef enum logic [1:0] {
    RK_PAD  = 2'd0,
    RK_DATA = 2'd1,
    RK_ISET = 2'd2,
    RK_FLAG = 2'd3
  } reg_kind_e;

  typedef enum logic [1:0] {
    DET_LEVEL = 2'd0,
    DET_RISE  = 2'd1,
    DET_FALL  = 2'd2,
    DET_BOTH  = 2'd3
  } det_mode_e;

  // interrupt setup word, bit 0 at the bottom
  typedef struct packed {
    logic             direct;
    logic [TGT_W-1:0] dest;
    logic             raw_en;
    det_mode_e        mode;
    logic             pol;
    logic             en;
  } iset_t;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic smp,
  output logic prv,
  output logic smp_ok,
  output logic hist_ok
);

  logic [STAGES-1:0] sh_q, sh_d;
  logic              prv_q, prv_d;
  logic [STAGES:0]   vld_q, vld_d;

  always_comb begin
    sh_d  = {sh_q[STAGES-2:0], din};
    prv_d = sh_q[STAGES-1];
    vld_d = {vld_q[STAGES-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      prv_q <= 1'b0;
      vld_q <= '0;
    end else begin
      sh_q  <= sh_d;
      prv_q <= prv_d;
      vld_q <= vld_d;
    end
  end

  assign smp     = sh_q[STAGES-1];
  assign prv     = prv_q;
  // sample valid once it has crossed all stages; history valid one later
  assign smp_ok  = vld_q[STAGES-1];
  assign hist_ok = vld_q[STAGES];

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_irq_pkg::*;
(
  input  det_mode_e mode,
  input  logic      pol,
  input  logic      smp,
  input  logic      prv,
  input  logic      smp_ok,
  input  logic      hist_ok,
  output logic      evt
);

  logic cur_act, old_act;

  always_comb begin
    cur_act = smp ~^ pol;
    old_act = prv ~^ pol;
    unique case (mode)
      DET_LEVEL: evt = smp_ok & cur_act;
      DET_RISE:  evt = hist_ok & cur_act & ~old_act;
      DET_FALL:  evt = hist_ok & ~cur_act & old_act;
      DET_BOTH:  evt = hist_ok & (cur_act ^ old_act);
      default:   evt = 1'b0;
    endcase
  end

endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
  import gpio_irq_pkg::*;
#(
  parameter int PROC_ID     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_pad,
  input  logic             wr_data,
  input  logic             wr_iset,
  input  logic             wr_flag,
  input  logic [CFG_W-1:0] wdata,
  input  logic             pin_raw,
  output logic [CFG_W-1:0] pad_q,
  output logic             out_q,
  output iset_t            iset_q,
  output logic             flag_q,
  output logic             smp,
  output logic             evt,
  output logic             qual
);

  logic [CFG_W-1:0] pad_d;
  logic             out_d;
  iset_t            iset_d;
  logic             flag_d;
  logic             prv, smp_ok, hist_ok;

  gpio_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (pin_raw),
    .smp     (smp),
    .prv     (prv),
    .smp_ok  (smp_ok),
    .hist_ok (hist_ok)
  );

  gpio_evt_detect u_det (
    .mode    (iset_q.mode),
    .pol     (iset_q.pol),
    .smp     (smp),
    .prv     (prv),
    .smp_ok  (smp_ok),
    .hist_ok (hist_ok),
    .evt     (evt)
  );

  always_comb begin
    pad_d  = pad_q;
    out_d  = out_q;
    iset_d = iset_q;
    flag_d = flag_q;
    if (wr_pad)  pad_d  = wdata;
    if (wr_data) out_d  = wdata[1];
    if (wr_iset) iset_d = iset_t'(wdata[ICFG_W-1:0]);
    if (wr_flag && !wdata[0]) flag_d = 1'b0;
    // a fresh event overrides a simultaneous clear
    if (iset_q.raw_en && evt) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_q  <= '0;
      out_q  <= 1'b0;
      iset_q <= '0;
      flag_q <= 1'b0;
    end else begin
      pad_q  <= pad_d;
      out_q  <= out_d;
      iset_q <= iset_d;
      flag_q <= flag_d;
    end
  end

  assign qual = flag_q & iset_q.en & ~iset_q.direct
              & (iset_q.dest == TGT_W'(PROC_ID));

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter  int NUM_PINS    = 4,
  parameter  int DATA_W      = 32,
  parameter  int PROC_ID     = 4,
  parameter  int SYNC_STAGES = 2,
  localparam int PIN_IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
  localparam int ADDR_W      = PIN_IDX_W + WIN_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq_out
);

  localparam logic [PIN_IDX_W:0] PIN_LIMIT = NUM_PINS[PIN_IDX_W:0];

  logic [PIN_IDX_W-1:0] a_pin;
  logic [WIN_BITS-1:0]  a_off;
  reg_kind_e            a_kind;
  logic                 off_ok, pin_ok;
  logic [DATA_W-1:0]    rdata_q, rdata_d;
  logic [DATA_W-1:0]    pin_word [NUM_PINS];
  logic [NUM_PINS-1:0]  flag_vec, evt_vec, raw_en_vec, qual_vec;
  logic                 unused_wdata;

  assign unused_wdata = ^reg_wdata[DATA_W-1:CFG_W];

  always_comb begin
    a_pin  = reg_addr[ADDR_W-1:WIN_BITS];
    a_off  = reg_addr[WIN_BITS-1:0];
    a_kind = reg_kind_e'(a_off[3:2]);
    off_ok = (a_off[WIN_BITS-1:4] == '0) && (a_off[1:0] == 2'b00);
    pin_ok = ({1'b0, a_pin} < PIN_LIMIT);
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic             hit;
    logic [CFG_W-1:0] pad_q;
    logic             out_q, flag_q, smp;
    iset_t            iset_q;

    assign hit = reg_we && off_ok && pin_ok && (a_pin == PIN_IDX_W'(p));

    gpio_pin_slice #(
      .PROC_ID     (PROC_ID),
      .SYNC_STAGES (SYNC_STAGES)
    ) u_slice (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_pad  (hit && (a_kind == RK_PAD)),
      .wr_data (hit && (a_kind == RK_DATA)),
      .wr_iset (hit && (a_kind == RK_ISET)),
      .wr_flag (hit && (a_kind == RK_FLAG)),
      .wdata   (reg_wdata[CFG_W-1:0]),
      .pin_raw (pin_in[p]),
      .pad_q   (pad_q),
      .out_q   (out_q),
      .iset_q  (iset_q),
      .flag_q  (flag_q),
      .smp     (smp),
      .evt     (evt_vec[p]),
      .qual    (qual_vec[p])
    );

    always_comb begin
      pin_word[p] = '0;
      unique case (a_kind)
        RK_PAD:  pin_word[p][CFG_W-1:0]  = pad_q;
        RK_DATA: pin_word[p][1:0]        = {out_q, smp};
        RK_ISET: pin_word[p][ICFG_W-1:0] = iset_q;
        RK_FLAG: pin_word[p][0]          = flag_q;
        default: pin_word[p]             = '0;
      endcase
    end

    assign pin_oe[p]     = pad_q[CFG_W-1];
    assign pin_out[p]    = out_q;
    assign flag_vec[p]   = flag_q;
    assign raw_en_vec[p] = iset_q.raw_en;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (reg_rd) rdata_d = (off_ok && pin_ok) ? pin_word[a_pin] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign reg_rdata = rdata_q;
  assign irq_out   = |qual_vec;

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int NUM_PINS = 4,
  parameter int ADDR_W   = 14,
  parameter int DATA_W   = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_we,
  input logic                reg_rd,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic                wbit0,
  input logic [DATA_W-1:0]   reg_rdata,
  input logic                irq_out,
  input logic [NUM_PINS-1:0] flag_vec,
  input logic [NUM_PINS-1:0] evt_vec,
  input logic [NUM_PINS-1:0] raw_en_vec
);

  // R1: summary line is quiet right after reset release
  p_quiet_at_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq_out);

  // R8: summary line needs at least one set flag
  p_irq_has_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (flag_vec != '0));

  // R10: read data holds without a read strobe
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
    logic clr_hit;
    assign clr_hit = reg_we && !wbit0 &&
                     (reg_addr == ADDR_W'((p * 4096) + 12));

    // R7: a clear with no coincident event drops the flag
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_hit && !(evt_vec[p] && raw_en_vec[p]) |=> !flag_vec[p]);

    // R4: a latched event sets the flag, even against a clear
    p_event_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
      evt_vec[p] && raw_en_vec[p] |=> flag_vec[p]);

    // R6: without raw latching a clear flag stays clear
    p_rawen_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !raw_en_vec[p] && !flag_vec[p] |=> !flag_vec[p]);
  end

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(
  .NUM_PINS (NUM_PINS),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_we     (reg_we),
  .reg_rd     (reg_rd),
  .reg_addr   (reg_addr),
  .wbit0      (reg_wdata[0]),
  .reg_rdata  (reg_rdata),
  .irq_out    (irq_out),
  .flag_vec   (flag_vec),
  .evt_vec    (evt_vec),
  .raw_en_vec (raw_en_vec)
);

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int AW = 14;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_we, reg_rd;
  logic [AW-1:0] reg_addr;
  logic [31:0]   reg_wdata, reg_rdata;
  logic [NP-1:0] pin_in, pin_out, pin_oe;
  logic          irq_out;
  logic          rd_pend = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_bank i_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  function automatic logic [AW-1:0] adr(input int p, input int o);
    return AW'(p * 4096 + o);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // driver: pushes the expected word, monitor compares it
  task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    q_exp.push_back(e); q_tag.push_back(tag);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) rd_pend <= reg_rd;

  // monitor
  always @(negedge clk) begin
    if (rd_pend) begin
      if (q_exp.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R10 actual=unexpected-read expected=queued");
      end else begin
        chk(reg_rdata, q_exp.pop_front(), q_tag.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_rd = 1'b0;
    reg_addr = '0; reg_wdata = '0; pin_in = 4'b0100;
    idle(3);
    chk({31'b0, irq_out}, 0, "R1 irq in reset");
    chk({28'b0, pin_oe}, 0, "R1 oe in reset");
    chk({28'b0, pin_out}, 0, "R1 out in reset");
    rst_n = 1'b1;

    // R9: pin 2 high through reset, rising detection armed at once
    wr(adr(2, 8), 32'h97);
    idle(4);
    rd(adr(2, 12), 0, "R9 no spurious edge");
    rd(adr(2, 4), 1, "R3 input high pin2");
    chk({31'b0, irq_out}, 0, "R9 irq quiet");
    rd(adr(0, 0), 0, "R1 pad pin0");
    rd(adr(0, 4), 0, "R1 data pin0");
    rd(adr(0, 8), 0, "R1 iset pin0");
    rd(adr(3, 12), 0, "R1 flag pin3");

    // R2/R3: windows, field widths, outputs
    wr(adr(1, 0), 32'hFFFF_FFFF);
    chk({28'b0, pin_oe}, 4'b0010, "R3 oe pin1");
    rd(adr(1, 0), 32'h3FF, "R2 pad width");
    wr(adr(1, 4), 32'h2);
    chk({28'b0, pin_out}, 4'b0010, "R3 out pin1");
    rd(adr(1, 4), 32'h2, "R2 data word");
    wr(adr(1, 8), 32'hFFFF);
    rd(adr(1, 8), 32'h1FF, "R2 iset width");
    wr(adr(1, 8), 32'h0);
    wr(adr(1, 16), 32'hFFFF);
    rd(adr(1, 16), 0, "R2 unused offset");
    wr(adr(3, 0), 32'h155);
    rd(adr(3, 0), 32'h155, "R2 pad pin3");
    rd(adr(1, 0), 32'h3FF, "R2 window isolation");
    chk({28'b0, pin_oe}, 4'b0010, "R3 oe pin3 off");

    @(negedge clk); pin_in[0] = 1'b1;
    idle(2);
    rd(adr(0, 4), 1, "R3 input sync pin0");

    // R5 rising on pin2
    @(negedge clk); pin_in[2] = 1'b0; idle(4);
    rd(adr(2, 12), 0, "R5 rise ignores fall");
    @(negedge clk); pin_in[2] = 1'b1; idle(4);
    rd(adr(2, 12), 1, "R5 rise latched");
    chk({31'b0, irq_out}, 1, "R8 irq on rise");
    wr(adr(2, 12), 0);
    rd(adr(2, 12), 0, "R7 clear");
    chk({31'b0, irq_out}, 0, "R8 irq after clear");
    wr(adr(2, 12), 1);
    rd(adr(2, 12), 0, "R7 write one no set");

    // R5 falling on pin0, then inverted rising
    wr(adr(0, 8), 32'h9B);
    @(negedge clk); pin_in[0] = 1'b0; idle(4);
    rd(adr(0, 12), 1, "R5 fall latched");
    wr(adr(0, 12), 1);
    rd(adr(0, 12), 1, "R7 write one keeps");
    wr(adr(0, 12), 0);
    wr(adr(0, 8), 32'h95);
    @(negedge clk); pin_in[0] = 1'b1; idle(4);
    rd(adr(0, 12), 0, "R5 inverted rise ignores rise");
    @(negedge clk); pin_in[0] = 1'b0; idle(4);
    rd(adr(0, 12), 1, "R5 inverted rise on fall");
    wr(adr(0, 12), 0);

    // R5 both edges on pin3
    wr(adr(3, 8), 32'h9F);
    @(negedge clk); pin_in[3] = 1'b1; idle(4);
    rd(adr(3, 12), 1, "R5 both rise");
    wr(adr(3, 12), 0);
    @(negedge clk); pin_in[3] = 1'b0; idle(4);
    rd(adr(3, 12), 1, "R5 both fall");
    wr(adr(3, 12), 0);
    rd(adr(3, 12), 0, "R7 clear pin3");

    // R4 level on pin1
    wr(adr(1, 8), 32'h93);
    idle(3);
    rd(adr(1, 12), 0, "R4 inactive level");
    @(negedge clk); pin_in[1] = 1'b1; idle(4);
    rd(adr(1, 12), 1, "R4 active level");
    wr(adr(1, 12), 0);
    rd(adr(1, 12), 1, "R4 clear loses to level");
    @(negedge clk); pin_in[1] = 1'b0; idle(4);
    wr(adr(1, 12), 0);
    rd(adr(1, 12), 0, "R4 clear after level gone");
    wr(adr(1, 8), 32'h91);
    idle(3);
    rd(adr(1, 12), 1, "R4 active low level");
    wr(adr(1, 8), 32'h0);
    wr(adr(1, 12), 0);
    rd(adr(1, 12), 0, "R4 cleared");

    // R6 raw latch off
    wr(adr(3, 8), 32'h8F);
    @(negedge clk); pin_in[3] = 1'b1; idle(4);
    @(negedge clk); pin_in[3] = 1'b0; idle(4);
    rd(adr(3, 12), 0, "R6 no latch");
    chk({31'b0, irq_out}, 0, "R6 irq quiet");

    // R6/R8: latching with enable off, then qualifier sweep on pin2
    wr(adr(2, 8), 32'h96);
    @(negedge clk); pin_in[2] = 1'b0; idle(4);
    @(negedge clk); pin_in[2] = 1'b1; idle(4);
    rd(adr(2, 12), 1, "R6 latch with enable off");
    chk({31'b0, irq_out}, 0, "R8 enable off");
    wr(adr(2, 8), 32'h97);
    chk({31'b0, irq_out}, 1, "R8 qualified");
    wr(adr(2, 8), 32'h77);
    chk({31'b0, irq_out}, 0, "R8 other dest");
    wr(adr(2, 8), 32'hF7);
    chk({31'b0, irq_out}, 0, "R8 dest none");
    wr(adr(2, 8), 32'h197);
    chk({31'b0, irq_out}, 0, "R8 direct routing");
    rd(adr(2, 12), 1, "R8 flag kept");
    wr(adr(2, 8), 32'h97);
    chk({31'b0, irq_out}, 1, "R8 requalified");
    wr(adr(2, 12), 0);
    chk({31'b0, irq_out}, 0, "R8 cleared");

    // R10: data holds without a read
    rd(adr(3, 0), 32'h155, "R10 read");
    idle(3);
    chk(reg_rdata, 32'h155, "R10 hold");

    idle(3);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule